// File: doc/BRIEF.md
# Public-Key Accelerator Control and Status Registers

This block is the register front-end that software uses to drive a public-key compute engine. A 32-bit bus with separate read and write strobes reaches eight registers. Through them software sets the engine mode (RSA or ECC) and the exponent and modulus lengths in bits. It also sets the external source address and length for operand DMA, chooses whether the engine or the CPU bus owns the operand SRAM, and turns on interrupt sources. A write to the command register that sets the start bit produces a one-cycle launch pulse toward the engine. When the DMA-load bit is set in the same write, the engine is also told to fetch its operands first.

The engine itself is not part of this block. Two handshake inputs stand for it: a ready pulse and a done pulse. Each pulse sets a sticky status bit. Software treats an operation as finished only when both status bits read as set. It then clears each bit by writing 1 to it, writes the command register back to zero, and claims the SRAM. The interrupt output is high whenever a set status bit also has its enable bit set.

Top module: `pka_csr`

## Requirements
- R1: After reset, every register reads zero and every engine-facing output and `irq` is low.
- R2: Byte offsets and readable fields: 0x00 command (bit 1 DMA-load is stored; bit 0 start always reads 0), 0x44 general control (all 32 bits), 0x48 mode/ownership (bits 5:4 mode, bit 8 CPU owns SRAM), 0x4C DMA source address (32 bits), 0x50 DMA length (bits 15:0), 0x58 operand sizes (bits 31:16 exponent bits, bits 15:0 modulus bits), 0x3F8 interrupt enable (bits 2:1), 0x3FC status (bits 2:1). All other bits read zero.
- R3: A read of any other offset returns zero, and a write to any other offset changes no register.
- R4: A write to 0x00 with bit 0 set raises `eng_start` for exactly the one cycle after the write. `eng_use_dma` follows the stored bit 1.
- R5: Once a start has been issued, further start writes are ignored until `eng_done` pulses. A start written after that pulse is accepted.
- R6: `eng_mode` follows bits 5:4 of 0x48 (3 is RSA, 2 is ECC), and `sram_cpu_owner` follows bit 8.
- R7: `eng_exp_bits`, `eng_mod_bits`, `dma_src_addr` and `dma_len` follow their register fields from the cycle after the write.
- R8: `eng_ready` sets status bit 2 and `eng_done` sets status bit 1. A set bit stays set until a 1 is written to its position at 0x3FC. Writing 0 there has no effect.
- R9: When a set pulse and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some status bit is set and its enable bit (same position at 0x3F8) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, committed at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| eng_ready | input | 1 | Engine ready pulse |
| eng_done | input | 1 | Engine completion pulse |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_use_dma | output | 1 | Load operands by DMA before computing |
| eng_mode | output | 2 | Engine mode selection |
| eng_exp_bits | output | 16 | Exponent length in bits |
| eng_mod_bits | output | 16 | Modulus length in bits |
| dma_src_addr | output | 32 | External DMA source address |
| dma_len | output | 16 | DMA transfer length |
| sram_cpu_owner | output | 1 | Operand SRAM is handed to the CPU bus |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle. These are: the launch pulse lasts one cycle, no launch appears while an operation is outstanding, status bits hold and obey their set and clear, unmapped reads return zero, and `irq` stays quiet when no source is enabled. Other behaviour can only be shown by the bench's scenarios. This covers the field masks and positions of each register and the lack of effect from writes to unmapped offsets. It also covers the point at which a rejected start becomes acceptable again after completion, and the full ready-plus-complete handshake that ends with software clearing both bits.

// File: rtl/pka_csr_pkg.sv
package pka_csr_pkg;

    localparam int DATA_W    = 32;
    localparam int HALF_W    = 16;
    localparam int MODE_W    = 2;
    localparam int STS_W     = 2;
    localparam int STS_LSB   = 1;
    localparam int START_BIT = 0;
    localparam int DMA_BIT   = 1;
    localparam int MODE_LSB  = 4;
    localparam int CPU_BIT   = 8;

    localparam int NUM_REGS  = 8;
    localparam int IDX_CMD   = 0;
    localparam int IDX_GEN   = 1;
    localparam int IDX_MODE  = 2;
    localparam int IDX_DSRC  = 3;
    localparam int IDX_DLEN  = 4;
    localparam int IDX_SIZE  = 5;
    localparam int IDX_IEN   = 6;
    localparam int IDX_ISTS  = 7;

    function automatic logic [31:0] reg_offset(input int idx);
        case (idx)
            IDX_CMD:  return 32'h000;
            IDX_GEN:  return 32'h044;
            IDX_MODE: return 32'h048;
            IDX_DSRC: return 32'h04C;
            IDX_DLEN: return 32'h050;
            IDX_SIZE: return 32'h058;
            IDX_IEN:  return 32'h3F8;
            default:  return 32'h3FC;
        endcase
    endfunction

    typedef struct packed {
        logic              use_dma;
        logic [DATA_W-1:0] gen_ctrl;
        logic              cpu_own;
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] dma_src;
        logic [HALF_W-1:0] dma_len;
        logic [HALF_W-1:0] exp_bits;
        logic [HALF_W-1:0] mod_bits;
        logic [STS_W-1:0]  int_en;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic busy;
    } launch_t;

    typedef struct packed {
        logic [STS_W-1:0] sts;
    } status_t;

endpackage

// File: rtl/pka_csr_decode.sv
module pka_csr_decode
    import pka_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(reg_offset(i)));
    end

endmodule

// File: rtl/pka_csr_regs.sv
module pka_csr_regs
    import pka_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_REGS-1:0] sel,
    input  logic [DATA_W-1:0]   wdata,
    output cfg_t                cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (sel[IDX_CMD])  cfg_d.use_dma  = wdata[DMA_BIT];
            if (sel[IDX_GEN])  cfg_d.gen_ctrl = wdata;
            if (sel[IDX_MODE]) begin
                cfg_d.cpu_own = wdata[CPU_BIT];
                cfg_d.mode    = wdata[MODE_LSB +: MODE_W];
            end
            if (sel[IDX_DSRC]) cfg_d.dma_src  = wdata;
            if (sel[IDX_DLEN]) cfg_d.dma_len  = wdata[HALF_W-1:0];
            if (sel[IDX_SIZE]) begin
                cfg_d.exp_bits = wdata[DATA_W-1:HALF_W];
                cfg_d.mod_bits = wdata[HALF_W-1:0];
            end
            if (sel[IDX_IEN])  cfg_d.int_en   = wdata[STS_LSB +: STS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pka_csr_launch.sv
module pka_csr_launch
    import pka_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic eng_done,
    output logic eng_start,
    output logic busy
);

    launch_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.start = 1'b0;
        if (eng_done) ln_d.busy = 1'b0;
        if (start_req && !ln_q.busy) begin
            ln_d.start = 1'b1;
            ln_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign eng_start = ln_q.start;
    assign busy      = ln_q.busy;

endmodule

// File: rtl/pka_csr_status.sv
module pka_csr_status
    import pka_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_bits,
    input  logic [STS_W-1:0] clr_bits,
    input  logic [STS_W-1:0] enable,
    output logic [STS_W-1:0] sts,
    output logic             irq
);

    status_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < STS_W; i++) begin
            if (clr_bits[i]) st_d.sts[i] = 1'b0;
            if (set_bits[i]) st_d.sts[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign irq = |(st_q.sts & enable);

endmodule

// File: rtl/pka_csr.sv
module pka_csr
    import pka_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_ready,
    input  logic              eng_done,
    output logic              eng_start,
    output logic              eng_use_dma,
    output logic [1:0]        eng_mode,
    output logic [15:0]       eng_exp_bits,
    output logic [15:0]       eng_mod_bits,
    output logic [31:0]       dma_src_addr,
    output logic [15:0]       dma_len,
    output logic              sram_cpu_owner,
    output logic              irq
);

    logic [NUM_REGS-1:0] sel;
    cfg_t                cfg;
    logic                start_req;
    logic                busy_w;
    logic [STS_W-1:0]    clr_w;
    logic [STS_W-1:0]    sts_w;
    logic [STS_W-1:0]    ien_w;

    pka_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pka_csr_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    assign start_req = bus_wr && sel[IDX_CMD] && bus_wdata[START_BIT];

    pka_csr_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .eng_done  (eng_done),
        .eng_start (eng_start),
        .busy      (busy_w)
    );

    assign clr_w = (bus_wr && sel[IDX_ISTS]) ? bus_wdata[STS_LSB +: STS_W] : '0;
    assign ien_w = cfg.int_en;

    pka_csr_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits ({eng_ready, eng_done}),
        .clr_bits (clr_w),
        .enable   (ien_w),
        .sts      (sts_w),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel[IDX_CMD])  bus_rdata[DMA_BIT] = cfg.use_dma;
            if (sel[IDX_GEN])  bus_rdata = cfg.gen_ctrl;
            if (sel[IDX_MODE]) begin
                bus_rdata[CPU_BIT]              = cfg.cpu_own;
                bus_rdata[MODE_LSB +: MODE_W]   = cfg.mode;
            end
            if (sel[IDX_DSRC]) bus_rdata = cfg.dma_src;
            if (sel[IDX_DLEN]) bus_rdata[HALF_W-1:0] = cfg.dma_len;
            if (sel[IDX_SIZE]) bus_rdata = {cfg.exp_bits, cfg.mod_bits};
            if (sel[IDX_IEN])  bus_rdata[STS_LSB +: STS_W] = cfg.int_en;
            if (sel[IDX_ISTS]) bus_rdata[STS_LSB +: STS_W] = sts_w;
        end
    end

    assign eng_use_dma    = cfg.use_dma;
    assign eng_mode       = cfg.mode;
    assign eng_exp_bits   = cfg.exp_bits;
    assign eng_mod_bits   = cfg.mod_bits;
    assign dma_src_addr   = cfg.dma_src;
    assign dma_len        = cfg.dma_len;
    assign sram_cpu_owner = cfg.cpu_own;

endmodule

// File: rtl/pka_csr_chk.sv
module pka_csr_chk
    import pka_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STS_W-1:0]  sts_wr_bits,
    input logic [31:0]       bus_rdata,
    input logic              eng_ready,
    input logic              eng_done,
    input logic              eng_start,
    input logic              eng_busy,
    input logic [STS_W-1:0]  sts_q,
    input logic [STS_W-1:0]  int_en_q,
    input logic              irq
);

    logic mapped;
    logic sts_wr;

    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < NUM_REGS; i++)
            if (bus_addr == ADDR_W'(reg_offset(i))) mapped = 1'b1;
    end

    assign sts_wr = bus_wr && (bus_addr == ADDR_W'(reg_offset(IDX_ISTS)));

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R4

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !eng_start); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> (bus_rdata == 32'h0)); // R3

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[1] && !(sts_wr && sts_wr_bits[1])) |=> sts_q[1]); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[0] && !(sts_wr && sts_wr_bits[0])) |=> sts_q[0]); // R8

    AST_READY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ready |=> sts_q[1]); // R9

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> sts_q[0]); // R9

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_wr_bits[0] && !eng_done) |=> !sts_q[0]); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en_q == '0) |-> !irq); // R10

endmodule

bind pka_csr pka_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .sts_wr_bits (bus_wdata[2:1]),
    .bus_rdata   (bus_rdata),
    .eng_ready   (eng_ready),
    .eng_done    (eng_done),
    .eng_start   (eng_start),
    .eng_busy    (busy_w),
    .sts_q       (sts_w),
    .int_en_q    (ien_w),
    .irq         (irq)
);

// File: tb/tb_pka_csr.sv
module tb_pka_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_ready = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_start, eng_use_dma, sram_cpu_owner, irq;
    logic [1:0]  eng_mode;
    logic [15:0] eng_exp_bits, eng_mod_bits, dma_len;
    logic [31:0] dma_src_addr;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    string       q_req[$];
    logic [31:0] q_exp[$];

    always #4 clk = ~clk;

    pka_csr dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_start(eng_start),
        .eng_use_dma(eng_use_dma), .eng_mode(eng_mode),
        .eng_exp_bits(eng_exp_bits), .eng_mod_bits(eng_mod_bits),
        .dma_src_addr(dma_src_addr), .dma_len(dma_len),
        .sram_cpu_owner(sram_cpu_owner), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expectations as read data appears
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (q_exp.size() == 0) chk("scoreboard-underflow", bus_rdata, 32'hx);
            else chk(q_req.pop_front(), bus_rdata, q_exp.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        q_req.push_back(req);
        q_exp.push_back(exp);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 start", {31'b0, eng_start}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 outputs", {eng_mode, eng_use_dma, sram_cpu_owner, dma_len}, 32'h0);
        rd(12'h000, 32'h0, "R1 cmd");
        rd(12'h044, 32'h0, "R1 gen");
        rd(12'h048, 32'h0, "R1 mode");
        rd(12'h058, 32'h0, "R1 size");
        rd(12'h3FC, 32'h0, "R1 status");

        // R2 field masks
        wr(12'h044, 32'hA5A5_0F0F);
        rd(12'h044, 32'hA5A5_0F0F, "R2 gen full");
        wr(12'h048, 32'hFFFF_FFFF);
        rd(12'h048, 32'h0000_0130, "R2 mode mask");
        wr(12'h3F8, 32'hFFFF_FFFF);
        rd(12'h3F8, 32'h0000_0006, "R2 enable mask");
        wr(12'h3F8, 32'h0);

        // R6 mode and ownership
        chk("R6 mode rsa", {30'b0, eng_mode}, 32'h3);
        chk("R6 cpu owner", {31'b0, sram_cpu_owner}, 32'h1);
        wr(12'h048, 32'h0000_0020);
        chk("R6 mode ecc", {30'b0, eng_mode}, 32'h2);
        chk("R6 engine owner", {31'b0, sram_cpu_owner}, 32'h0);

        // R7 sizes and DMA
        wr(12'h058, 32'h0011_0800);
        chk("R7 exp bits", {16'b0, eng_exp_bits}, 32'h0011);
        chk("R7 mod bits", {16'b0, eng_mod_bits}, 32'h0800);
        rd(12'h058, 32'h0011_0800, "R7 size readback");
        wr(12'h04C, 32'hDEAD_BEEF);
        chk("R7 dma src", dma_src_addr, 32'hDEAD_BEEF);
        wr(12'h050, 32'hABCD_1234);
        chk("R7 dma len", {16'b0, dma_len}, 32'h1234);
        rd(12'h050, 32'h0000_1234, "R2 dma len mask");

        // R3 unmapped offsets
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h3F4, 32'hFFFF_FFFF);
        rd(12'h004, 32'h0, "R3 unmapped read");
        rd(12'h3F4, 32'h0, "R3 unmapped read high");
        rd(12'h044, 32'hA5A5_0F0F, "R3 gen untouched");
        rd(12'h3F8, 32'h0, "R3 enable untouched");
        chk("R3 no start", {31'b0, eng_start}, 32'h0);

        // R4 launch pulse
        wr(12'h000, 32'h3);
        chk("R4 start pulse", {31'b0, eng_start}, 32'h1);
        chk("R4 dma select", {31'b0, eng_use_dma}, 32'h1);
        idle(1);
        chk("R4 pulse ends", {31'b0, eng_start}, 32'h0);
        rd(12'h000, 32'h2, "R4 start reads 0");

        // R5 start while busy ignored
        wr(12'h000, 32'h1);
        chk("R5 busy ignore", {31'b0, eng_start}, 32'h0);
        chk("R4 dma bit rewritten", {31'b0, eng_use_dma}, 32'h0);
        eng_ready = 1'b1; idle(1); eng_ready = 1'b0;
        rd(12'h3FC, 32'h4, "R8 ready sticky");
        eng_done = 1'b1; idle(1); eng_done = 1'b0;
        rd(12'h3FC, 32'h6, "R8 both set");
        wr(12'h000, 32'h1);
        chk("R5 start after done", {31'b0, eng_start}, 32'h1);
        idle(1);
        eng_done = 1'b1; idle(1); eng_done = 1'b0;

        // R8 write-0 no effect, W1C per bit
        wr(12'h3FC, 32'h0);
        rd(12'h3FC, 32'h6, "R8 write zero ignored");
        wr(12'h3FC, 32'h2);
        rd(12'h3FC, 32'h4, "R8 clear complete only");

        // R10 interrupt gating
        chk("R10 disabled", {31'b0, irq}, 32'h0);
        wr(12'h3F8, 32'h2);
        chk("R10 other source", {31'b0, irq}, 32'h0);
        wr(12'h3F8, 32'h4);
        chk("R10 ready enabled", {31'b0, irq}, 32'h1);

        // R9 set wins over clear
        eng_ready = 1'b1;
        wr(12'h3FC, 32'h4);
        eng_ready = 1'b0;
        rd(12'h3FC, 32'h4, "R9 set beats clear");
        wr(12'h3FC, 32'h6);
        rd(12'h3FC, 32'h0, "R8 both cleared");
        chk("R10 irq drops", {31'b0, irq}, 32'h0);
        eng_done = 1'b1; idle(1); eng_done = 1'b0;
        wr(12'h3F8, 32'h6);
        chk("R10 complete enabled", {31'b0, irq}, 32'h1);
        wr(12'h000, 32'h0);
        chk("R4 cmd cleared", {31'b0, eng_use_dma}, 32'h0);

        idle(2);
        chk("scoreboard drained", q_exp.size(), 32'h0);
        finish_run();
    end

endmodule